// File: doc/BRIEF.md
# Double-Buffered SPI Master

This block is an SPI master that sits on a simple CPU register bus. Each byte that software writes to the data register is shifted out most significant bit first on the serial output. At the same time a byte is shifted in from the serial input. The serial clock runs at exactly half the system clock, so a frame takes 16 system clock cycles. Only SPI mode 0 is supported: the serial clock idles low, the master changes its output on falling edges, and it samples its input on rising edges.

A transmit holding register sits between the bus and the shifter. Software can queue the next byte while the current frame is still shifting, and the queued byte starts on the very next serial clock period, so a burst runs with no idle clocks between frames. Received bytes go into a small queue, two entries deep by default, which software drains by reading the data register. A status register reports five flags: holding register free, received data waiting, transfer complete, write collision, and receive overrun. A separate register drives the chip-select output.

Read-only transfers are done by sending 0xFF: every byte sent produces exactly one received byte.

Top module: `spi_dbuf_master`

## Requirements
- R1: After reset the serial clock and serial output are low, chip select is high (inactive), and the status register (address 1) reads 0x01: only bit 0, holding register free, is set.
- R2: Writing address 2 sets the chip-select level from data bit 0, where 1 drives `spi_cs_n` low. Reading address 2 returns that bit.
- R3: Writing address 0 while the holding register is free starts an 8-bit frame. The frame is sent MSB first in mode 0 and has 8 rising serial clock edges spanning 14 system clocks, or 16 system clocks per frame in all. The byte shifted in on `spi_miso` goes to the receive queue.
- R4: Status bit 0 (holding register free) reads 0 from the data write until the shifter takes the byte. It reads 1 again while that byte is still shifting.
- R5: A byte queued before the current frame ends starts with no gap: its first rising serial clock edge comes 2 system clocks after the last rising edge of the previous frame.
- R6: Status bit 1 (received data waiting) is 1 while the receive queue holds a byte. Reading address 0 returns the oldest byte and removes it. Two bytes received back to back can both be read afterwards.
- R7: Status bit 2 (transfer complete) is set when a frame ends with the holding register empty. It is cleared only when a status read that saw it set is followed by a data-register access (read or write). Neither a status read alone nor a data access alone clears it.
- R8: A data write while the holding register is full is ignored: that byte never appears on `spi_mosi`. It sets sticky status bit 3, which a status read clears after returning it.
- R9: A byte that completes while the receive queue is full, with no data read in that cycle, is discarded. It sets sticky status bit 4, which a status read clears after returning it.
- R10: A data read that falls in the same cycle as a frame completing into a full queue frees a slot, so the new byte is kept and no overrun is flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 2 | Register select: 0 data, 1 status, 2 chip select |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_rd | input | 1 | Single-cycle read strobe (reads of data and status have side effects) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the cycle of the read strobe |
| spi_sck | output | 1 | Serial clock, idles low |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | 1 | Chip select, active low |

## Verification
The case that needs the most care is a frame finishing and pushing a byte into a full receive queue in the same clock edge that software pops the queue with a data read. The bench fills the queue with two frames and then starts a third. It counts from the write edge to place a data read exactly on the 17th edge, where the third frame completes. It then judges the result from the overrun bit, which must stay clear, and from the two bytes read afterwards, which must be the older survivor and the new byte. The tighter pairing of transfer-complete set against its clear sequence is covered by the flag priority: a new completion wins.

// File: rtl/spi_dbuf_pkg.sv
package spi_dbuf_pkg;
   localparam int ADDR_W = 2;

   typedef enum logic [ADDR_W-1:0] {
      REG_DATA = 2'd0,
      REG_STAT = 2'd1,
      REG_CSEL = 2'd2
   } reg_sel_e;

   // status bit positions
   localparam int ST_TXE = 0;
   localparam int ST_RXC = 1;
   localparam int ST_TC  = 2;
   localparam int ST_COL = 3;
   localparam int ST_OVR = 4;
   localparam int ST_BITS = 5;
endpackage

// File: rtl/spi_dbuf_shifter.sv
module spi_dbuf_shifter #(
   parameter int FRAME_W = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [FRAME_W-1:0] wr_data,
   output logic               hold_free,
   output logic               collide,
   output logic               frame_end,
   output logic               drained,
   output logic [FRAME_W-1:0] rx_word,
   output logic               sck,
   output logic               mosi,
   input  logic               miso
);
   localparam int CNT_W = (FRAME_W > 2) ? $clog2(FRAME_W) : 1;
   localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_W - 1);

   if (FRAME_W < 2) begin : g_bad_width
      $error("spi_dbuf_shifter: FRAME_W must be at least 2");
   end

   logic               hold_full_q;
   logic [FRAME_W-1:0] hold_q;
   logic [FRAME_W-1:0] tx_sh_q;
   logic [FRAME_W-1:0] rx_sh_q;
   logic               busy_q;
   logic               sck_q;
   logic [CNT_W-1:0]   bit_q;

   logic accept, last_fall, load;

   assign accept    = wr_en & ~hold_full_q;
   assign last_fall = busy_q & sck_q & (bit_q == LAST_BIT);
   assign load      = hold_full_q & (~busy_q | last_fall);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_full_q <= 1'b0;
         hold_q      <= '0;
         tx_sh_q     <= '0;
         rx_sh_q     <= '0;
         busy_q      <= 1'b0;
         sck_q       <= 1'b0;
         bit_q       <= '0;
      end else begin
         if (accept) begin
            hold_q      <= wr_data;
            hold_full_q <= 1'b1;
         end else if (load) begin
            hold_full_q <= 1'b0;
         end

         if (load) begin
            busy_q  <= 1'b1;
            tx_sh_q <= hold_q;
            bit_q   <= '0;
            sck_q   <= 1'b0;
         end else if (busy_q) begin
            if (!sck_q) begin
               sck_q   <= 1'b1;
               rx_sh_q <= {rx_sh_q[FRAME_W-2:0], miso};
            end else begin
               sck_q <= 1'b0;
               if (last_fall) begin
                  busy_q <= 1'b0;
               end else begin
                  bit_q   <= bit_q + 1'b1;
                  tx_sh_q <= {tx_sh_q[FRAME_W-2:0], 1'b0};
               end
            end
         end
      end
   end

   assign hold_free = ~hold_full_q;
   assign collide   = wr_en & hold_full_q;
   assign frame_end = last_fall;
   assign drained   = last_fall & ~hold_full_q;
   assign rx_word   = rx_sh_q;
   assign sck       = sck_q;
   assign mosi      = busy_q & tx_sh_q[FRAME_W-1];

   // R3: the serial clock toggles every system clock while a frame runs
   assert_sck_toggles_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && $past(busy_q)) |-> (sck_q != $past(sck_q)));

   // R3: the serial clock rests low whenever no frame is active
   assert_sck_idle_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_q |-> !sck_q);

   // R5: a queued byte starts on the next serial clock period
   assert_gapless_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (last_fall && hold_full_q) |=> (busy_q && !sck_q && bit_q == '0));

   // R8: a write into a full holding register leaves it untouched
   assert_hold_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && hold_full_q) |=> $stable(hold_q));
endmodule

// File: rtl/spi_dbuf_rxq.sv
module spi_dbuf_rxq #(
   parameter int WIDTH = 8,
   parameter int DEPTH = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [WIDTH-1:0] push_data,
   input  logic             pop,
   output logic [WIDTH-1:0] head,
   output logic             not_empty,
   output logic             dropped
);
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CNT_W = $clog2(DEPTH + 1);
   localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("spi_dbuf_rxq: DEPTH must be a power of two, at least 2");
   end

   logic [WIDTH-1:0] mem_q [DEPTH];
   logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
   logic [CNT_W-1:0] count_q;
   logic             pop_ok, push_ok, is_full;

   assign is_full = (count_q == FULL_CNT);
   assign pop_ok  = pop & (count_q != '0);
   assign push_ok = push & (~is_full | pop_ok);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr_q <= '0;
         rd_ptr_q <= '0;
         count_q  <= '0;
         for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
      end else begin
         if (push_ok) begin
            mem_q[wr_ptr_q] <= push_data;
            wr_ptr_q        <= wr_ptr_q + 1'b1;
         end
         if (pop_ok) rd_ptr_q <= rd_ptr_q + 1'b1;
         if (push_ok && !pop_ok)      count_q <= count_q + 1'b1;
         else if (pop_ok && !push_ok) count_q <= count_q - 1'b1;
      end
   end

   assign head      = mem_q[rd_ptr_q];
   assign not_empty = (count_q != '0);
   assign dropped   = push & ~push_ok;

   // R9: occupancy never exceeds the queue depth
   assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
      count_q <= FULL_CNT);

   // R9: a push into a full queue without a pop leaves it full
   assert_drop_keeps_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (push && is_full && !pop) |=> (count_q == FULL_CNT));

   // R10: simultaneous push and pop on a full queue keeps it full
   assert_swap_when_full_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (push && pop && is_full) |=> (count_q == FULL_CNT));
endmodule

// File: rtl/spi_dbuf_flags.sv
module spi_dbuf_flags (
   input  logic clk,
   input  logic rst_n,
   input  logic stat_rd,
   input  logic data_acc,
   input  logic drained,
   input  logic collide,
   input  logic dropped,
   output logic tc,
   output logic col,
   output logic ovr
);
   logic tc_q, arm_q, col_q, ovr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tc_q  <= 1'b0;
         arm_q <= 1'b0;
         col_q <= 1'b0;
         ovr_q <= 1'b0;
      end else begin
         if (stat_rd)       arm_q <= tc_q;
         else if (data_acc) arm_q <= 1'b0;

         if (drained)                tc_q <= 1'b1;
         else if (data_acc && arm_q) tc_q <= 1'b0;

         if (collide)      col_q <= 1'b1;
         else if (stat_rd) col_q <= 1'b0;

         if (dropped)      ovr_q <= 1'b1;
         else if (stat_rd) ovr_q <= 1'b0;
      end
   end

   assign tc  = tc_q;
   assign col = col_q;
   assign ovr = ovr_q;

   // R7: an armed data access clears transfer complete
   assert_tc_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (arm_q && data_acc && !drained) |=> !tc_q);

   // R7: without the armed sequence the flag holds
   assert_tc_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (tc_q && !(arm_q && data_acc)) |=> tc_q);

   // R8: a collision is always recorded
   assert_col_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      collide |=> col_q);

   // R9: a dropped byte is always recorded
   assert_ovr_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      dropped |=> ovr_q);
endmodule

// File: rtl/spi_dbuf_master.sv
module spi_dbuf_master
   import spi_dbuf_pkg::*;
#(
   parameter int FRAME_W  = 8,
   parameter int RX_DEPTH = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic               bus_wr,
   input  logic               bus_rd,
   input  logic [FRAME_W-1:0] bus_wdata,
   output logic [FRAME_W-1:0] bus_rdata,
   output logic               spi_sck,
   output logic               spi_mosi,
   input  logic               spi_miso,
   output logic               spi_cs_n
);
   if (FRAME_W < ST_BITS) begin : g_bad_status_width
      $error("spi_dbuf_master: FRAME_W too narrow for the status register");
   end

   logic data_wr, data_rd, stat_rd, csel_wr, data_acc;
   logic hold_free, collide, frame_end, drained;
   logic rxq_ne, dropped, tc, col, ovr;
   logic [FRAME_W-1:0] rx_word, rx_head, stat_v;
   logic cs_q;

   assign data_wr  = bus_wr & (bus_addr == REG_DATA);
   assign data_rd  = bus_rd & (bus_addr == REG_DATA);
   assign stat_rd  = bus_rd & (bus_addr == REG_STAT);
   assign csel_wr  = bus_wr & (bus_addr == REG_CSEL);
   assign data_acc = data_wr | data_rd;

   spi_dbuf_shifter #(.FRAME_W(FRAME_W)) shifter_i (
      .clk(clk), .rst_n(rst_n),
      .wr_en(data_wr), .wr_data(bus_wdata),
      .hold_free(hold_free), .collide(collide),
      .frame_end(frame_end), .drained(drained), .rx_word(rx_word),
      .sck(spi_sck), .mosi(spi_mosi), .miso(spi_miso)
   );

   spi_dbuf_rxq #(.WIDTH(FRAME_W), .DEPTH(RX_DEPTH)) rxq_i (
      .clk(clk), .rst_n(rst_n),
      .push(frame_end), .push_data(rx_word),
      .pop(data_rd), .head(rx_head),
      .not_empty(rxq_ne), .dropped(dropped)
   );

   spi_dbuf_flags flags_i (
      .clk(clk), .rst_n(rst_n),
      .stat_rd(stat_rd), .data_acc(data_acc),
      .drained(drained), .collide(collide), .dropped(dropped),
      .tc(tc), .col(col), .ovr(ovr)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cs_q <= 1'b0;
      else if (csel_wr) cs_q <= bus_wdata[0];
   end
   assign spi_cs_n = ~cs_q;

   always_comb begin
      stat_v         = '0;
      stat_v[ST_TXE] = hold_free;
      stat_v[ST_RXC] = rxq_ne;
      stat_v[ST_TC]  = tc;
      stat_v[ST_COL] = col;
      stat_v[ST_OVR] = ovr;
   end

   always_comb begin
      unique case (bus_addr)
         REG_DATA: bus_rdata = rxq_ne ? rx_head : '0;
         REG_STAT: bus_rdata = stat_v;
         REG_CSEL: bus_rdata = {{(FRAME_W-1){1'b0}}, cs_q};
         default:  bus_rdata = '0;
      endcase
   end

   // R2: chip select follows the last write to its register
   assert_cs_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
      csel_wr |=> (spi_cs_n == !$past(bus_wdata[0])));

   // R6: received data waiting is reported right after a frame ends
   assert_rxc_after_frame_R6: assert property (@(posedge clk) disable iff (!rst_n)
      frame_end |=> rxq_ne);
endmodule

// File: tb/spi_dbuf_master_tb.sv
`timescale 1ns/1ps
module spi_dbuf_master_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] bus_addr = 2'd0;
   logic       wr_s = 1'b0, rd_s = 1'b0;
   logic [7:0] bus_wdata = 8'd0;
   logic [7:0] bus_rdata;
   logic       spi_sck, spi_mosi, spi_miso, spi_cs_n;

   int nchecks = 0;
   int nfail   = 0;

   always #2.5 clk = ~clk;

   spi_dbuf_master dut_i (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(wr_s), .bus_rd(rd_s),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .spi_sck(spi_sck),
      .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_cs_n(spi_cs_n)
   );

   // slave model: frame k returns k*37+11, bits change after each rising edge
   function automatic logic [7:0] slave_byte(input int k);
      return 8'((k * 37 + 11) & 255);
   endfunction

   int         rcnt = 0;
   longint     rise_t [0:4095];
   logic [7:0] mlog [0:511];
   logic [7:0] msh = 8'd0;
   logic [7:0] sb;

   always_comb begin
      sb       = slave_byte(rcnt >> 3);
      spi_miso = sb[3'd7 - 3'(rcnt)];
   end

   always @(posedge spi_sck) begin
      rise_t[rcnt & 4095] = $time;
      if ((rcnt & 7) == 7) mlog[(rcnt >> 3) & 511] = {msh[6:0], spi_mosi};
      msh  = {msh[6:0], spi_mosi};
      rcnt = rcnt + 1;
   end

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      nchecks++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; wr_s = 1'b1;
      @(posedge clk); #1;
      wr_s = 1'b0;
   endtask

   task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
      @(negedge clk);
      bus_addr = a; rd_s = 1'b1;
      #1 d = bus_rdata;
      @(posedge clk); #1;
      rd_s = 1'b0;
   endtask

   task automatic poll(input int bitn, output logic [7:0] st);
      st = 8'd0;
      for (int n = 0; n < 200; n++) begin
         bus_read(2'd1, st);
         if (st[bitn]) break;
      end
      chk(st[bitn], "poll status", st, 1 << bitn);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      nfail++;
      $display("FAIL watchdog actual=expired expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
      $finish;
   end

   initial begin : stim
      logic [7:0] st, d;
      int kb;
      repeat (5) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      // R1 reset state
      chk(spi_sck == 1'b0 && spi_mosi == 1'b0, "R1 sck/mosi low", {spi_sck, spi_mosi}, 0);
      chk(spi_cs_n == 1'b1, "R1 cs_n high", spi_cs_n, 1);
      bus_read(2'd1, st);
      chk(st == 8'h01, "R1 status", st, 8'h01);

      // R2 chip select
      bus_write(2'd2, 8'h01);
      chk(spi_cs_n == 1'b0, "R2 cs asserted", spi_cs_n, 0);
      bus_read(2'd2, d);
      chk(d == 8'h01, "R2 readback", d, 1);

      // R3/R4/R6/R7 sweep of every byte value
      for (int v = 0; v < 256; v++) begin
         kb = rcnt >> 3;
         bus_write(2'd0, 8'(v));
         bus_read(2'd1, st);
         chk(st[0] == 1'b0, "R4 txe low after write", st, 0);
         bus_read(2'd1, st);
         chk(st[0] == 1'b1 && st[2] == 1'b0, "R4 txe high while shifting", st, 1);
         poll(2, st);
         chk(st[1] == 1'b1, "R6 rxc set", st, 2);
         bus_read(2'd0, d);
         chk(d == slave_byte(kb), "R3 received byte", d, slave_byte(kb));
         chk(mlog[kb & 511] == 8'(v), "R3 sent byte msb first", mlog[kb & 511], v);
         chk(rise_t[(8*kb+7) & 4095] - rise_t[(8*kb) & 4095] == 70,
             "R3 frame length", rise_t[(8*kb+7) & 4095] - rise_t[(8*kb) & 4095], 70);
         bus_read(2'd1, st);
         chk(st[2:1] == 2'b00, "R7 tc cleared by sequence, R6 queue empty", st, 0);
      end

      // R5 gapless pair, R6 two-deep read back
      kb = rcnt >> 3;
      bus_write(2'd0, 8'hA5);
      poll(0, st);
      bus_write(2'd0, 8'h3C);
      poll(2, st);
      chk(rise_t[(8*kb+8) & 4095] - rise_t[(8*kb+7) & 4095] == 10, "R5 no gap",
          rise_t[(8*kb+8) & 4095] - rise_t[(8*kb+7) & 4095], 10);
      bus_read(2'd0, d);
      chk(d == slave_byte(kb), "R6 first of two", d, slave_byte(kb));
      bus_read(2'd0, d);
      chk(d == slave_byte(kb+1), "R6 second of two", d, slave_byte(kb+1));
      chk(mlog[(kb+1) & 511] == 8'h3C, "R5 second byte sent", mlog[(kb+1) & 511], 8'h3C);
      bus_read(2'd1, st);
      chk(st[1] == 1'b0, "R6 queue drained", st, 0);

      // R8 write collision
      kb = rcnt >> 3;
      bus_write(2'd0, 8'h81);
      poll(0, st);
      bus_write(2'd0, 8'h42);
      bus_write(2'd0, 8'hE7);
      bus_read(2'd1, st);
      chk(st[3] == 1'b1 && st[0] == 1'b0, "R8 collision flagged", st, 8'h08);
      bus_read(2'd1, st);
      chk(st[3] == 1'b0, "R8 collision cleared by status read", st, 0);
      poll(2, st);
      repeat (40) @(posedge clk);
      chk((rcnt >> 3) == kb + 2, "R8 only two frames", rcnt >> 3, kb + 2);
      chk(mlog[kb & 511] == 8'h81 && mlog[(kb+1) & 511] == 8'h42, "R8 ignored byte not sent",
          {mlog[kb & 511], mlog[(kb+1) & 511]}, 16'h8142);
      bus_read(2'd0, d);
      bus_read(2'd0, d);
      chk(d == slave_byte(kb+1), "R8 rx intact", d, slave_byte(kb+1));

      // R9 receive overrun
      kb = rcnt >> 3;
      bus_write(2'd0, 8'h11);
      poll(0, st);
      bus_write(2'd0, 8'h22);
      poll(2, st);
      bus_write(2'd0, 8'h33);
      poll(2, st);
      chk(st[4] == 1'b1 && st[1] == 1'b1, "R9 overrun flagged", st, 8'h12);
      bus_read(2'd1, st);
      chk(st[4] == 1'b0, "R9 overrun cleared by status read", st, 0);
      bus_read(2'd0, d);
      chk(d == slave_byte(kb), "R9 oldest kept", d, slave_byte(kb));
      bus_read(2'd0, d);
      chk(d == slave_byte(kb+1), "R9 second kept", d, slave_byte(kb+1));
      bus_read(2'd1, st);
      chk(st[1] == 1'b0, "R9 third byte dropped", st, 0);

      // R7 clear rules
      kb = rcnt >> 3;
      bus_write(2'd0, 8'hFF);
      repeat (40) @(posedge clk);
      bus_read(2'd0, d);
      chk(d == slave_byte(kb), "R7 read-only transfer byte", d, slave_byte(kb));
      bus_read(2'd1, st);
      chk(st[2] == 1'b1, "R7 data access alone keeps tc", st, 4);
      bus_read(2'd1, st);
      chk(st[2] == 1'b1, "R7 status read alone keeps tc", st, 4);
      bus_read(2'd0, d);
      bus_read(2'd1, st);
      chk(st[2] == 1'b0, "R7 armed data access clears tc", st, 0);

      // R10 pop and push in the same cycle on a full queue
      kb = rcnt >> 3;
      bus_write(2'd0, 8'h5A);
      poll(0, st);
      bus_write(2'd0, 8'hC3);
      poll(2, st);
      bus_write(2'd0, 8'h96);
      repeat (16) @(posedge clk);
      bus_read(2'd0, d);
      chk(d == slave_byte(kb), "R10 head at collision edge", d, slave_byte(kb));
      poll(2, st);
      chk(st[4] == 1'b0, "R10 no overrun on same-cycle pop", st, 0);
      bus_read(2'd0, d);
      chk(d == slave_byte(kb+1), "R10 survivor", d, slave_byte(kb+1));
      bus_read(2'd0, d);
      chk(d == slave_byte(kb+2), "R10 new byte kept", d, slave_byte(kb+2));

      // R2 release
      bus_write(2'd2, 8'h00);
      chk(spi_cs_n == 1'b1, "R2 cs released", spi_cs_n, 1);
      chk(spi_sck == 1'b0, "R3 sck idles low", spi_sck, 0);

      $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
      $finish;
   end
endmodule